// File: doc/BRIEF.md
# Dual-Port Mailbox Handshake Controller

This block is a shared mailbox that sits between a host processor and a local processor. Both sides see the same fifteen byte-wide data registers and one control/status register, each through its own synchronous register port. A port has an address, a read strobe, a write strobe, write data and registered read data. A message is finished by writing the highest data register. That write raises a write-end flag, which the other side sees. When the other side reads the same register, the flag clears.

The local processor gets a level interrupt when the host has finished a message and the interrupt is enabled. In slave mode, an optional ready line goes back to the host. Particular register accesses drive it low and high, so the host can pace its transfers against the local side. A host-owned master-write-mode bit records which side currently fills the data registers. That bit qualifies one of the ready-low conditions.

Top module: `mbox_hs_top`

## Requirements
- R1: Either port writes data registers at addresses 0 to 14. A read strobe returns the content held before that clock edge on the port's read data, one cycle later; the read data holds otherwise.
- R2: When both ports write the same data register in one cycle, the host value is stored.
- R3: Status bit 7 (master write end) sets when the host writes address 14 and clears when the local side reads address 14; set wins when both happen in one cycle.
- R4: Status bit 5 (slave write end) sets when the local side writes address 14 and clears when the host reads address 14; set wins when both happen in one cycle.
- R5: `irq_o` equals, one cycle late, status bit 7 AND status bit 6 (interrupt enable).
- R6: A write to address 15 sets bits 6 and 4 from either port, and bit 0 (master write mode) from the host only. Bits 7 and 5 ignore such writes. Bits 3..1 read 0. When both ports write address 15 in one cycle, the host value is used.
- R7: `rdy_o` is high one cycle after any cycle in which `slave_mode` is 0 or status bit 4 (ready enable) is 0.
- R8: With ready active, `rdy_o` goes low after the local side reads address 0 while bit 0 is 1, or after the local side writes address 14.
- R9: With ready active, `rdy_o` goes high after a host read of address 14 or 15, or a write of address 0 by either port. When a high and a low event coincide, high wins.
- R10: After reset, all registers, flags, enables and read data are 0, `irq_o` is 0 and `rdy_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slave_mode | input | 1 | Selects the mode in which the ready line is handshake-driven |
| h_rd | input | 1 | Host read strobe |
| h_wr | input | 1 | Host write strobe |
| h_addr | input | 4 | Host register address (0-14 data, 15 status) |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data, registered |
| l_rd | input | 1 | Local read strobe |
| l_wr | input | 1 | Local write strobe |
| l_addr | input | 4 | Local register address (0-14 data, 15 status) |
| l_wdata | input | 8 | Local write data |
| l_rdata | output | 8 | Local read data, registered |
| irq_o | output | 1 | Master-write-end interrupt to the local processor |
| rdy_o | output | 1 | Ready/acknowledge line to the host |

## Verification
On every cycle, the assertions check the flag set and clear rules with set priority, the one-cycle interrupt relation, the forced-high ready line outside slave mode or without ready enable, and the ready transitions, high-over-low included. The bench's scenarios are needed to show the data path: storage and registered read-back, the host winning a same-register write, and the status bits that the local port cannot change. It does this by comparing both read ports against a model under random and directed traffic.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 4;
    localparam int NUM_DATA  = 15;
    localparam int FIRST_IDX = 0;
    localparam int LAST_IDX  = NUM_DATA - 1;
    localparam int CSR_IDX   = NUM_DATA;

    localparam int B_MWE = 7;
    localparam int B_IEN = 6;
    localparam int B_SWE = 5;
    localparam int B_REN = 4;
    localparam int B_MWM = 0;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        logic  rd;
        logic  wr;
        addr_t addr;
        byte_t wdata;
    } port_req_t;

    typedef struct packed {
        logic mwe;
        logic ien;
        logic swe;
        logic ren;
        logic mwm;
    } csr_t;

    typedef struct packed {
        logic mwe_set, mwe_clr;
        logic swe_set, swe_clr;
        logic rdy_lo,  rdy_hi;
    } hs_evt_t;

    function automatic logic hit_rd(port_req_t p, int idx);
        return p.rd && (p.addr == addr_t'(idx));
    endfunction

    function automatic logic hit_wr(port_req_t p, int idx);
        return p.wr && (p.addr == addr_t'(idx));
    endfunction

    function automatic hs_evt_t decode_evt(port_req_t h, port_req_t l, logic mwm);
        hs_evt_t e;
        e.mwe_set = hit_wr(h, LAST_IDX);
        e.mwe_clr = hit_rd(l, LAST_IDX);
        e.swe_set = hit_wr(l, LAST_IDX);
        e.swe_clr = hit_rd(h, LAST_IDX);
        e.rdy_lo  = (hit_rd(l, FIRST_IDX) && mwm) || hit_wr(l, LAST_IDX);
        e.rdy_hi  = hit_rd(h, LAST_IDX) || hit_rd(h, CSR_IDX) ||
                    hit_wr(h, FIRST_IDX) || hit_wr(l, FIRST_IDX);
        return e;
    endfunction

    function automatic byte_t pack_csr(csr_t c);
        byte_t b = '0;
        b[B_MWE] = c.mwe;
        b[B_IEN] = c.ien;
        b[B_SWE] = c.swe;
        b[B_REN] = c.ren;
        b[B_MWM] = c.mwm;
        return b;
    endfunction

    function automatic logic upd_flag(logic cur, logic set, logic clr);
        return set ? 1'b1 : (clr ? 1'b0 : cur);
    endfunction
endpackage

// File: rtl/mbox_regfile.sv
module mbox_regfile
    import mbox_pkg::*;
#(
    parameter int NUM = NUM_DATA,
    parameter int DW  = DATA_W,
    parameter int AW  = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          h_wr,
    input  logic [AW-1:0] h_addr,
    input  logic [DW-1:0] h_wdata,
    input  logic          l_wr,
    input  logic [AW-1:0] l_addr,
    input  logic [DW-1:0] l_wdata,
    output logic [DW-1:0] h_val,
    output logic [DW-1:0] l_val
);
    logic [NUM-1:0][DW-1:0] mem_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_q <= '0;
        end else begin
            for (int i = 0; i < NUM; i++) begin
                if (h_wr && h_addr == AW'(i))
                    mem_q[i] <= h_wdata;
                else if (l_wr && l_addr == AW'(i))
                    mem_q[i] <= l_wdata;
            end
        end
    end

    always_comb begin
        h_val = '0;
        l_val = '0;
        for (int i = 0; i < NUM; i++) begin
            if (h_addr == AW'(i)) h_val = mem_q[i];
            if (l_addr == AW'(i)) l_val = mem_q[i];
        end
    end
endmodule

// File: rtl/mbox_flags.sv
module mbox_flags
    import mbox_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  hs_evt_t evt,
    input  logic    ien,
    output logic    mwe,
    output logic    swe,
    output logic    irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mwe <= 1'b0;
            swe <= 1'b0;
            irq <= 1'b0;
        end else begin
            mwe <= upd_flag(mwe, evt.mwe_set, evt.mwe_clr);
            swe <= upd_flag(swe, evt.swe_set, evt.swe_clr);
            irq <= mwe & ien;
        end
    end
endmodule

// File: rtl/mbox_ready.sv
module mbox_ready (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic go_lo,
    input  logic go_hi,
    output logic rdy
);
    always_ff @(posedge clk) begin
        if (rst)         rdy <= 1'b1;
        else if (!active) rdy <= 1'b1;
        else if (go_hi)  rdy <= 1'b1;
        else if (go_lo)  rdy <= 1'b0;
    end
endmodule

// File: rtl/mbox_hs_top.sv
module mbox_hs_top
    import mbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              slave_mode,
    input  logic              h_rd,
    input  logic              h_wr,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [DATA_W-1:0] h_wdata,
    output logic [DATA_W-1:0] h_rdata,
    input  logic              l_rd,
    input  logic              l_wr,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic              irq_o,
    output logic              rdy_o
);
    port_req_t h_req, l_req;
    hs_evt_t   evt;
    logic      ien_q, ren_q, mwm_q;
    logic      mwe_w, swe_w;
    byte_t     h_mem, l_mem, stat_b;
    csr_t      stat;

    assign h_req = '{rd: h_rd, wr: h_wr, addr: h_addr, wdata: h_wdata};
    assign l_req = '{rd: l_rd, wr: l_wr, addr: l_addr, wdata: l_wdata};
    assign evt   = decode_evt(h_req, l_req, mwm_q);

    mbox_regfile #(.NUM(NUM_DATA), .DW(DATA_W), .AW(ADDR_W)) u_regs (
        .clk(clk), .rst(rst),
        .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata),
        .l_wr(l_wr), .l_addr(l_addr), .l_wdata(l_wdata),
        .h_val(h_mem), .l_val(l_mem)
    );

    mbox_flags u_flags (
        .clk(clk), .rst(rst), .evt(evt), .ien(ien_q),
        .mwe(mwe_w), .swe(swe_w), .irq(irq_o)
    );

    mbox_ready u_rdy (
        .clk(clk), .rst(rst), .active(slave_mode & ren_q),
        .go_lo(evt.rdy_lo), .go_hi(evt.rdy_hi), .rdy(rdy_o)
    );

    // control bits: host write is applied last, so it wins
    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q <= 1'b0;
            ren_q <= 1'b0;
            mwm_q <= 1'b0;
        end else begin
            if (hit_wr(l_req, CSR_IDX)) begin
                ien_q <= l_wdata[B_IEN];
                ren_q <= l_wdata[B_REN];
            end
            if (hit_wr(h_req, CSR_IDX)) begin
                ien_q <= h_wdata[B_IEN];
                ren_q <= h_wdata[B_REN];
                mwm_q <= h_wdata[B_MWM];
            end
        end
    end

    assign stat   = '{mwe: mwe_w, ien: ien_q, swe: swe_w, ren: ren_q, mwm: mwm_q};
    assign stat_b = pack_csr(stat);

    always_ff @(posedge clk) begin
        if (rst) begin
            h_rdata <= '0;
            l_rdata <= '0;
        end else begin
            if (h_rd) h_rdata <= (h_addr == addr_t'(CSR_IDX)) ? stat_b : h_mem;
            if (l_rd) l_rdata <= (l_addr == addr_t'(CSR_IDX)) ? stat_b : l_mem;
        end
    end
endmodule

// File: rtl/mbox_hs_chk.sv
module mbox_hs_chk
    import mbox_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              slave_mode,
    input logic              h_rd,
    input logic              h_wr,
    input logic [ADDR_W-1:0] h_addr,
    input logic              l_rd,
    input logic              l_wr,
    input logic [ADDR_W-1:0] l_addr,
    input logic              irq_o,
    input logic              rdy_o,
    input logic              mwe,
    input logic              swe,
    input logic              ien,
    input logic              ren,
    input logic              mwm
);
    logic h_w14, h_r14, l_w14, l_r14, act, hi_ev, lo_ev;
    assign h_w14 = h_wr && h_addr == addr_t'(LAST_IDX);
    assign h_r14 = h_rd && h_addr == addr_t'(LAST_IDX);
    assign l_w14 = l_wr && l_addr == addr_t'(LAST_IDX);
    assign l_r14 = l_rd && l_addr == addr_t'(LAST_IDX);
    assign act   = slave_mode && ren;
    assign hi_ev = h_r14 || (h_rd && h_addr == addr_t'(CSR_IDX)) ||
                   (h_wr && h_addr == '0) || (l_wr && l_addr == '0);
    assign lo_ev = (l_rd && l_addr == '0 && mwm) || l_w14;

    a_r3_mwe_set: assert property (@(posedge clk) disable iff (rst) h_w14 |=> mwe);
    a_r3_mwe_clr: assert property (@(posedge clk) disable iff (rst) (l_r14 && !h_w14) |=> !mwe);
    a_r4_swe_set: assert property (@(posedge clk) disable iff (rst) l_w14 |=> swe);
    a_r4_swe_clr: assert property (@(posedge clk) disable iff (rst) (h_r14 && !l_w14) |=> !swe);
    a_r5_irq_on:  assert property (@(posedge clk) disable iff (rst) (mwe && ien) |=> irq_o);
    a_r5_irq_off: assert property (@(posedge clk) disable iff (rst) !(mwe && ien) |=> !irq_o);
    a_r7_rdy_idle: assert property (@(posedge clk) disable iff (rst) !act |=> rdy_o);
    a_r8_rdy_low: assert property (@(posedge clk) disable iff (rst) (act && lo_ev && !hi_ev) |=> !rdy_o);
    a_r9_rdy_high: assert property (@(posedge clk) disable iff (rst) (act && hi_ev) |=> rdy_o);
    a_r9_rdy_hold: assert property (@(posedge clk) disable iff (rst)
                                    (act && !hi_ev && !lo_ev) |=> $stable(rdy_o));
endmodule

bind mbox_hs_top mbox_hs_chk chk_i (
    .clk(clk), .rst(rst), .slave_mode(slave_mode),
    .h_rd(h_rd), .h_wr(h_wr), .h_addr(h_addr),
    .l_rd(l_rd), .l_wr(l_wr), .l_addr(l_addr),
    .irq_o(irq_o), .rdy_o(rdy_o),
    .mwe(mwe_w), .swe(swe_w), .ien(ien_q), .ren(ren_q), .mwm(mwm_q)
);

// File: tb/mbox_hs_top_tb_top.sv
module mbox_hs_top_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic slave_mode = 1'b0;
    logic h_rd = 0, h_wr = 0, l_rd = 0, l_wr = 0;
    logic [3:0] h_addr = 0, l_addr = 0;
    logic [7:0] h_wdata = 0, l_wdata = 0;
    logic [7:0] h_rdata, l_rdata;
    logic irq_o, rdy_o;

    int n_chk = 0, n_fail = 0;

    // reference model state
    logic [7:0] m_mem [15];
    logic m_mwe, m_swe, m_ien, m_ren, m_mwm, m_irq, m_rdy;
    logic [7:0] m_hrd, m_lrd;

    always #2 clk = ~clk;

    mbox_hs_top dut_i (
        .clk(clk), .rst(rst), .slave_mode(slave_mode),
        .h_rd(h_rd), .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
        .l_rd(l_rd), .l_wr(l_wr), .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
        .irq_o(irq_o), .rdy_o(rdy_o)
    );

    function automatic logic [7:0] m_read(logic [3:0] a);
        if (a == 4'd15) return {m_mwe, m_ien, m_swe, m_ren, 3'b000, m_mwm};
        return m_mem[a];
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 15; i++) m_mem[i] = 8'h00;
        {m_mwe, m_swe, m_ien, m_ren, m_mwm, m_irq} = '0;
        m_rdy = 1'b1; m_hrd = 8'h00; m_lrd = 8'h00;
    endtask

    task automatic model_step();
        logic act, lo, hi;
        logic [7:0] nh, nl;
        nh = h_rd ? m_read(h_addr) : m_hrd;
        nl = l_rd ? m_read(l_addr) : m_lrd;
        act = slave_mode && m_ren;
        lo = (l_rd && l_addr == 0 && m_mwm) || (l_wr && l_addr == 14);
        hi = (h_rd && (h_addr == 14 || h_addr == 15)) || (h_wr && h_addr == 0) || (l_wr && l_addr == 0);
        m_irq = m_mwe && m_ien;
        m_rdy = !act ? 1'b1 : (hi ? 1'b1 : (lo ? 1'b0 : m_rdy));
        if (h_wr && h_addr == 14) m_mwe = 1'b1; else if (l_rd && l_addr == 14) m_mwe = 1'b0;
        if (l_wr && l_addr == 14) m_swe = 1'b1; else if (h_rd && h_addr == 14) m_swe = 1'b0;
        if (l_wr && l_addr == 15) begin m_ien = l_wdata[6]; m_ren = l_wdata[4]; end
        if (h_wr && h_addr == 15) begin m_ien = h_wdata[6]; m_ren = h_wdata[4]; m_mwm = h_wdata[0]; end
        if (l_wr && l_addr < 15) m_mem[l_addr] = l_wdata;
        if (h_wr && h_addr < 15) m_mem[h_addr] = h_wdata;
        m_hrd = nh; m_lrd = nl;
    endtask

    task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic op(string tag, logic hr, logic hw, logic [3:0] ha, logic [7:0] hd,
                      logic lr, logic lw, logic [3:0] la, logic [7:0] ld);
        @(negedge clk);
        h_rd = hr; h_wr = hw; h_addr = ha; h_wdata = hd;
        l_rd = lr; l_wr = lw; l_addr = la; l_wdata = ld;
        @(posedge clk);
        model_step();
        #1;
        check(tag, "h_rdata", h_rdata, m_hrd);
        check(tag, "l_rdata", l_rdata, m_lrd);
        check(tag, "irq_o", {7'd0, irq_o}, {7'd0, m_irq});
        check(tag, "rdy_o", {7'd0, rdy_o}, {7'd0, m_rdy});
    endtask

    task automatic idle(string tag); op(tag, 0,0,0,0, 0,0,0,0); endtask
    task automatic hrd(string tag, logic [3:0] a); op(tag, 1,0,a,0, 0,0,0,0); endtask
    task automatic hwr(string tag, logic [3:0] a, logic [7:0] d); op(tag, 0,1,a,d, 0,0,0,0); endtask
    task automatic lrd(string tag, logic [3:0] a); op(tag, 0,0,0,0, 1,0,a,0); endtask
    task automatic lwr(string tag, logic [3:0] a, logic [7:0] d); op(tag, 0,0,0,0, 0,1,a,d); endtask

    function automatic logic [3:0] pick_addr();
        int r = $urandom_range(0, 7);
        if (r < 2) return 4'd0;
        if (r < 4) return 4'd14;
        if (r < 5) return 4'd15;
        return 4'($urandom_range(1, 13));
    endfunction

    initial begin
        repeat (400000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        // R10 reset state
        idle("R10"); hrd("R10", 15); lrd("R10", 3);
        // R1 storage and read-back
        hwr("R1", 3, 8'hA5); lrd("R1", 3); lwr("R1", 7, 8'h3C); hrd("R1", 7); idle("R1");
        // R2 same-register collision
        op("R2", 0,1,5,8'h11, 0,1,5,8'h22); hrd("R2", 5); lrd("R2", 5);
        // R3 master write end
        hwr("R3", 14, 8'h77); hrd("R3", 15); lrd("R3", 14); lrd("R3", 15);
        op("R3", 0,1,14,8'h01, 1,0,14,0); lrd("R3", 15); lrd("R3", 14);
        // R4 slave write end
        lwr("R4", 14, 8'h55); lrd("R4", 15); hrd("R4", 14); hrd("R4", 15);
        op("R4", 1,0,14,0, 0,1,14,8'h02); hrd("R4", 15); hrd("R4", 14);
        // R5 interrupt
        hwr("R5", 15, 8'h40); hwr("R5", 14, 8'h09); idle("R5"); idle("R5");
        lrd("R5", 14); idle("R5"); idle("R5");
        // R6 local status write cannot set mode, flags untouched
        lwr("R6", 15, 8'hFF); hrd("R6", 15);
        op("R6", 0,1,15,8'h01, 0,1,15,8'h50); lrd("R6", 15);
        // R7 ready not driven outside slave mode
        slave_mode = 1'b0; hwr("R7", 15, 8'h11); lwr("R7", 14, 8'h00); idle("R7");
        // R8 / R9 ready in slave mode
        slave_mode = 1'b1; idle("R8"); lrd("R8", 0); idle("R8");
        hrd("R9", 14); lwr("R8", 14, 8'h03); hrd("R9", 15);
        lrd("R8", 0); op("R9", 0,1,0,8'h44, 0,1,14,8'h05);
        lwr("R8", 14, 8'h06); lwr("R9", 0, 8'h07);
        lwr("R8", 14, 8'h08); lwr("R7", 15, 8'h00); idle("R7");
        // random traffic
        for (int n = 0; n < 4000; n++) begin
            if (n % 500 == 0) slave_mode = 1'($urandom_range(0, 1));
            op("R1/R3/R8", 1'($urandom), 1'($urandom), pick_addr(), 8'($urandom),
                           1'($urandom), 1'($urandom), pick_addr(), 8'($urandom));
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule